// File: doc/BRIEF.md
# Pause Control Frame Transmit Sequencer

This block sends a full-duplex flow-control PAUSE frame when software asks for one. Software raises a transmit-pause request. The block then asks the normal data transmitter to stop after its current frame. When the data path reports that it is idle, the block pulses a stop-complete interrupt and streams out the control frame one byte per beat. The frame leaves on a valid/ready/last byte stream, which a downstream framer extends with preamble and FCS. When the last byte has been accepted, the request and the stop both drop on their own, and data traffic resumes.

The frame holds these fields in order: the reserved multicast destination 01-80-C2-00-00-01, the station's own source address, the MAC-control type 0x8808, the pause opcode 0x0001 and the programmed pause duration. Zero padding then brings the frame to the minimum length, which excludes the FCS. A request made in half-duplex mode is dropped. A request made while a pause frame is already being sent is held and is served after a short gap.

Top module: `pause_tx_seq`

## Requirements
- R1: A `pause_req_set` pulse while `full_duplex` is low has no effect: `gstop_req`, `pause_req_bit` and `tx_valid` stay low.
- R2: A `pause_req_set` pulse with `full_duplex` high, while the block is idle, drives `gstop_req` and `pause_req_bit` high from the next cycle onward. After reset both are low.
- R3: While `data_idle` is low, no stop is confirmed. In the cycle after a clock edge at which `data_idle` is high during a pending stop, `gsc_irq` is high for exactly one cycle.
- R4: `tx_valid` first rises in the same cycle as the `gsc_irq` pulse, and it is never high while `gstop_req` is low.
- R5: Frame bytes 0 to 17 are, most significant byte first: 01 80 C2 00 00 01, the six bytes of `station_addr`, 88 08, 00 01, and the two bytes of `pause_quanta`.
- R6: Bytes 18 to MIN_LEN-1 (59 by default) are 0x00. `tx_last` is high only with byte MIN_LEN-1.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R8: In the cycle after the handshake of the last byte, `gstop_req` and `pause_req_bit` are low, unless a queued request exists (see R9).
- R9: A full-duplex request made while a frame is being sent is kept. After the current frame, `gstop_req` is low for exactly one cycle, then a second stop-and-send sequence starts.
- R10: `station_addr` and `pause_quanta` are captured at the edge that confirms the stop. Later changes do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Full-duplex mode enable |
| pause_req_set | input | 1 | One-cycle software request to send a pause frame |
| station_addr | input | 48 | Station source address, first byte in bits 47:40 |
| pause_quanta | input | 16 | Programmed pause duration |
| data_idle | input | 1 | Normal transmit path has no frame in progress |
| gstop_req | output | 1 | Graceful stop request to the data path |
| pause_req_bit | output | 1 | Transmit-pause request status, cleared by the block |
| gsc_irq | output | 1 | One-cycle stop-complete interrupt |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block with its default parameters: six source-address bytes, two duration bytes, a 60-byte minimum with padding enabled, and request queuing enabled. With these values the full padded frame is checked byte by byte, the one-cycle gap between two queued sequences can be seen, and the capture of address and duration can be told apart from the live inputs. Stall patterns on `tx_ready` and a data path that stays busy for several cycles exercise the hold and wait behaviour.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_STOP = 2'd1,
      SEQ_SEND = 2'd2
   } seq_state_t;

   localparam logic [47:0] CTRL_DST_MAC = 48'h0180_C200_0001;
   localparam logic [15:0] CTRL_ETYPE   = 16'h8808;
   localparam logic [15:0] CTRL_OPCODE  = 16'h0001;
   localparam int          DST_BYTES    = 6;
   localparam int          TYPE_OP_BYTES = 4;

endpackage

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
   import pause_tx_pkg::*;
#(
   parameter int QUEUE_REPEAT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       full_duplex,
   input  logic       pause_req_set,
   input  logic       data_idle,
   input  logic       frame_done,
   output seq_state_t state,
   output logic       stop_active,
   output logic       irq_pulse,
   output logic       snap_en
);

   seq_state_t state_q, state_d;
   logic       queued_q;
   logic       irq_q;
   logic       accept_new;

   assign accept_new = pause_req_set & full_duplex;
   assign snap_en    = (state_q == SEQ_STOP) & data_idle;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (queued_q || accept_new) state_d = SEQ_STOP;
         SEQ_STOP: if (data_idle) state_d = SEQ_SEND;
         SEQ_SEND: if (frame_done) state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= snap_en;
      end
   end

   generate
      if (QUEUE_REPEAT != 0) begin : g_queue
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               queued_q <= 1'b0;
            end else if (state_q == SEQ_SEND && accept_new) begin
               queued_q <= 1'b1;
            end else if (state_q == SEQ_IDLE) begin
               queued_q <= 1'b0;
            end
         end
      end else begin : g_no_queue
         assign queued_q = 1'b0;
      end
   endgenerate

   assign state       = state_q;
   assign stop_active = (state_q != SEQ_IDLE);
   assign irq_pulse   = irq_q;

endmodule

// File: rtl/pause_hdr_snap.sv
module pause_hdr_snap
   import pause_tx_pkg::*;
#(
   parameter int SA_BYTES  = 6,
   parameter int DUR_BYTES = 2,
   localparam int SA_W      = SA_BYTES * 8,
   localparam int DUR_W     = DUR_BYTES * 8,
   localparam int HDR_BYTES = DST_BYTES + SA_BYTES + TYPE_OP_BYTES + DUR_BYTES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   snap_en,
   input  logic [SA_W-1:0]        station_addr,
   input  logic [DUR_W-1:0]       pause_quanta,
   output logic [HDR_BYTES*8-1:0] hdr_flat
);

   localparam int SA_OFS  = DST_BYTES;
   localparam int TO_OFS  = DST_BYTES + SA_BYTES;
   localparam int DUR_OFS = TO_OFS + TYPE_OP_BYTES;

   logic [SA_W-1:0]  sa_q;
   logic [DUR_W-1:0] dur_q;
   logic [31:0]      type_op;

   assign type_op = {CTRL_ETYPE, CTRL_OPCODE};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sa_q  <= '0;
         dur_q <= '0;
      end else if (snap_en) begin
         sa_q  <= station_addr;
         dur_q <= pause_quanta;
      end
   end

   generate
      for (genvar i = 0; i < DST_BYTES; i++) begin : g_dst
         assign hdr_flat[(HDR_BYTES-1-i)*8 +: 8] = CTRL_DST_MAC[(DST_BYTES-1-i)*8 +: 8];
      end
      for (genvar i = 0; i < SA_BYTES; i++) begin : g_sa
         assign hdr_flat[(HDR_BYTES-1-SA_OFS-i)*8 +: 8] = sa_q[(SA_BYTES-1-i)*8 +: 8];
      end
      for (genvar i = 0; i < TYPE_OP_BYTES; i++) begin : g_to
         assign hdr_flat[(HDR_BYTES-1-TO_OFS-i)*8 +: 8] = type_op[(TYPE_OP_BYTES-1-i)*8 +: 8];
      end
      for (genvar i = 0; i < DUR_BYTES; i++) begin : g_dur
         assign hdr_flat[(HDR_BYTES-1-DUR_OFS-i)*8 +: 8] = dur_q[(DUR_BYTES-1-i)*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/pause_byte_emitter.sv
module pause_byte_emitter #(
   parameter int HDR_BYTES = 18,
   parameter int FRAME_LEN = 60,
   localparam int IDX_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sending,
   input  logic [HDR_BYTES*8-1:0] hdr_flat,
   output logic [7:0]             tx_data,
   output logic                   tx_valid,
   input  logic                   tx_ready,
   output logic                   tx_last,
   output logic                   frame_done
);

   logic [IDX_W-1:0] idx_q;
   logic             beat;

   assign tx_valid   = sending;
   assign tx_last    = sending & (idx_q == IDX_W'(FRAME_LEN - 1));
   assign beat       = sending & tx_ready;
   assign frame_done = beat & tx_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (beat) begin
         idx_q <= tx_last ? '0 : idx_q + 1'b1;
      end
   end

   always_comb begin
      tx_data = 8'h00;
      for (int k = 0; k < HDR_BYTES; k++) begin
         if (idx_q == IDX_W'(k)) tx_data = hdr_flat[(HDR_BYTES-1-k)*8 +: 8];
      end
   end

endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq
   import pause_tx_pkg::*;
#(
   parameter int SA_BYTES     = 6,
   parameter int DUR_BYTES    = 2,
   parameter int MIN_LEN      = 60,
   parameter int PAD_EN       = 1,
   parameter int QUEUE_REPEAT = 1,
   localparam int SA_W        = SA_BYTES * 8,
   localparam int DUR_W       = DUR_BYTES * 8,
   localparam int HDR_BYTES   = DST_BYTES + SA_BYTES + TYPE_OP_BYTES + DUR_BYTES,
   localparam int FRAME_LEN   = (PAD_EN != 0) ? MIN_LEN : HDR_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             full_duplex,
   input  logic             pause_req_set,
   input  logic [SA_W-1:0]  station_addr,
   input  logic [DUR_W-1:0] pause_quanta,
   input  logic             data_idle,
   output logic             gstop_req,
   output logic             pause_req_bit,
   output logic             gsc_irq,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic             tx_last
);

   generate
      if (SA_BYTES < 1 || DUR_BYTES < 1) begin : g_bad_fields
         $error("pause_tx_seq: field byte counts must be at least one");
      end
      if (PAD_EN != 0 && MIN_LEN < HDR_BYTES) begin : g_bad_len
         $error("pause_tx_seq: MIN_LEN shorter than the control header");
      end
   endgenerate

   seq_state_t             state;
   logic                   stop_active;
   logic                   snap_en;
   logic                   frame_done;
   logic [HDR_BYTES*8-1:0] hdr_flat;

   pause_req_ctrl #(
      .QUEUE_REPEAT(QUEUE_REPEAT)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .full_duplex  (full_duplex),
      .pause_req_set(pause_req_set),
      .data_idle    (data_idle),
      .frame_done   (frame_done),
      .state        (state),
      .stop_active  (stop_active),
      .irq_pulse    (gsc_irq),
      .snap_en      (snap_en)
   );

   pause_hdr_snap #(
      .SA_BYTES (SA_BYTES),
      .DUR_BYTES(DUR_BYTES)
   ) u_snap (
      .clk         (clk),
      .rst_n       (rst_n),
      .snap_en     (snap_en),
      .station_addr(station_addr),
      .pause_quanta(pause_quanta),
      .hdr_flat    (hdr_flat)
   );

   pause_byte_emitter #(
      .HDR_BYTES(HDR_BYTES),
      .FRAME_LEN(FRAME_LEN)
   ) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sending   (state == SEQ_SEND),
      .hdr_flat  (hdr_flat),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_last   (tx_last),
      .frame_done(frame_done)
   );

   assign gstop_req     = stop_active;
   assign pause_req_bit = stop_active;

endmodule

// File: rtl/pause_tx_seq_chk.sv
module pause_tx_seq_chk #(
   parameter int FRAME_LEN = 60,
   localparam int CNT_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       full_duplex,
   input logic       pause_req_set,
   input logic       data_idle,
   input logic       gstop_req,
   input logic       pause_req_bit,
   input logic       gsc_irq,
   input logic [7:0] tx_data,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       tx_last
);

   logic             done;
   logic [CNT_W-1:0] beats_q;

   assign done = tx_valid & tx_ready & tx_last;

   always_ff @(posedge clk) begin
      if (!rst_n) beats_q <= '0;
      else if (tx_valid && tx_ready) beats_q <= tx_last ? '0 : beats_q + 1'b1;
   end

   assert_hd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!gstop_req && !full_duplex && pause_req_set && !$past(done)) |=> !gstop_req);

   assert_irq_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gsc_irq |-> ($past(data_idle) && gstop_req));

   assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gsc_irq |=> !gsc_irq);

   assert_valid_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> gsc_irq);

   assert_valid_under_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (gstop_req && pause_req_bit));

   assert_last_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_last) |-> (beats_q == CNT_W'(FRAME_LEN - 1)));

   assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   assert_clear_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!gstop_req && !pause_req_bit));

endmodule

bind pause_tx_seq pause_tx_seq_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (.*);

// File: tb/sim_pause_tx_seq.sv
module sim_pause_tx_seq;

   localparam int MIN_LEN = 60;
   localparam int HDR     = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_duplex = 1'b0;
   logic        pause_req_set = 1'b0;
   logic [47:0] station_addr = '0;
   logic [15:0] pause_quanta = '0;
   logic        data_idle = 1'b1;
   logic        gstop_req, pause_req_bit, gsc_irq, tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] got [MIN_LEN];
   int got_n;

   always #2 clk = ~clk;

   pause_tx_seq u0 (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
      .pause_req_set(pause_req_set), .station_addr(station_addr),
      .pause_quanta(pause_quanta), .data_idle(data_idle),
      .gstop_req(gstop_req), .pause_req_bit(pause_req_bit), .gsc_irq(gsc_irq),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int k, input logic [47:0] sa, input logic [15:0] dur);
      logic [47:0] dst = 48'h0180_C200_0001;
      if (k < 6)  return dst[(5-k)*8 +: 8];
      if (k < 12) return sa[(11-k)*8 +: 8];
      if (k == 12) return 8'h88;
      if (k == 13) return 8'h08;
      if (k == 14) return 8'h00;
      if (k == 15) return 8'h01;
      if (k == 16) return dur[15:8];
      if (k == 17) return dur[7:0];
      return 8'h00;
   endfunction

   task automatic recv_frame(input int stall);
      int cyc = 0;
      logic hold = 1'b0;
      logic [7:0] held_d = '0;
      got_n = 0;
      while (got_n < MIN_LEN && cyc < 2000) begin
         tx_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
         if (hold) begin
            chk("R7 valid held", tx_valid, 1);
            chk("R7 data held", tx_data, held_d);
         end
         if (tx_valid && tx_ready) begin
            got[got_n] = tx_data;
            chk("R6 last flag", tx_last, (got_n == MIN_LEN - 1));
            got_n++;
            hold = 1'b0;
         end else if (tx_valid) begin
            hold = 1'b1;
            held_d = tx_data;
         end
         cyc++;
         @(negedge clk);
      end
      tx_ready = 1'b1;
      chk("R6 frame length", got_n, MIN_LEN);
   endtask

   task automatic cmp_frame(input logic [47:0] sa, input logic [15:0] dur, input string tag);
      for (int k = 0; k < MIN_LEN; k++) begin
         if (k < HDR) chk({tag, " R5 header byte"}, got[k], exp_byte(k, sa, dur));
         else chk({tag, " R6 pad byte"}, got[k], 8'h00);
      end
   endtask

   task automatic t_reset;
      chk("R2 reset gstop", gstop_req, 0);
      chk("R2 reset req bit", pause_req_bit, 0);
      chk("R3 reset irq", gsc_irq, 0);
      chk("R4 reset valid", tx_valid, 0);
   endtask

   task automatic t_half_duplex;
      full_duplex = 1'b0;
      pause_req_set = 1'b1;
      @(negedge clk);
      pause_req_set = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R1 gstop stays low", gstop_req, 0);
         chk("R1 req bit stays low", pause_req_bit, 0);
         chk("R1 no frame", tx_valid, 0);
         @(negedge clk);
      end
   endtask

   task automatic t_basic;
      station_addr = 48'h0012_3456_789A;
      pause_quanta = 16'hBEEF;
      full_duplex = 1'b1;
      data_idle = 1'b0;
      tx_ready = 1'b0;
      pause_req_set = 1'b1;
      @(negedge clk);
      pause_req_set = 1'b0;
      chk("R2 gstop raised", gstop_req, 1);
      chk("R2 req bit raised", pause_req_bit, 1);
      for (int i = 0; i < 3; i++) begin
         chk("R3 no irq while busy", gsc_irq, 0);
         chk("R4 no valid before irq", tx_valid, 0);
         @(negedge clk);
      end
      data_idle = 1'b1;
      @(negedge clk);
      chk("R3 irq pulse", gsc_irq, 1);
      chk("R4 valid with irq", tx_valid, 1);
      chk("R5 first byte", tx_data, 8'h01);
      @(negedge clk);
      chk("R3 irq one cycle", gsc_irq, 0);
      chk("R7 stalled valid", tx_valid, 1);
      chk("R7 stalled data", tx_data, 8'h01);
      recv_frame(0);
      chk("R8 gstop cleared", gstop_req, 0);
      chk("R8 req bit cleared", pause_req_bit, 0);
      chk("R8 valid cleared", tx_valid, 0);
      cmp_frame(48'h0012_3456_789A, 16'hBEEF, "basic");
      @(negedge clk);
      chk("R8 stays idle", gstop_req, 0);
   endtask

   task automatic t_snapshot_stall;
      station_addr = 48'hA1B2_C3D4_E5F6;
      pause_quanta = 16'h0102;
      tx_ready = 1'b0;
      pause_req_set = 1'b1;
      @(negedge clk);
      pause_req_set = 1'b0;
      @(negedge clk);
      chk("R3 irq immediate when idle", gsc_irq, 1);
      station_addr = 48'hFFFF_0000_FFFF;
      pause_quanta = 16'h7777;
      recv_frame(1);
      cmp_frame(48'hA1B2_C3D4_E5F6, 16'h0102, "R10 snapshot");
      chk("R8 cleared after stalled frame", gstop_req, 0);
   endtask

   task automatic t_queue;
      station_addr = 48'h0203_0405_0607;
      pause_quanta = 16'hFFFF;
      tx_ready = 1'b0;
      pause_req_set = 1'b1;
      @(negedge clk);
      pause_req_set = 1'b0;
      @(negedge clk);
      chk("R9 first irq", gsc_irq, 1);
      pause_req_set = 1'b1;
      @(negedge clk);
      pause_req_set = 1'b0;
      recv_frame(0);
      cmp_frame(48'h0203_0405_0607, 16'hFFFF, "R9 first");
      chk("R9 gap cycle gstop", gstop_req, 0);
      chk("R9 gap cycle req bit", pause_req_bit, 0);
      @(negedge clk);
      chk("R9 second stop", gstop_req, 1);
      tx_ready = 1'b0;
      @(negedge clk);
      chk("R9 second irq", gsc_irq, 1);
      recv_frame(0);
      cmp_frame(48'h0203_0405_0607, 16'hFFFF, "R9 second");
      chk("R9 done after second", gstop_req, 0);
      @(negedge clk);
      chk("R9 no third sequence", gstop_req, 0);
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_half_duplex();
      t_basic();
      t_snapshot_stall();
      t_queue();
      report();
   end

endmodule